// File: doc/BRIEF.md
# Keyed Flash Erase and Write Guard

This block sits between a register bus and the command inputs of a flash controller. The register bus can be driven by the CPU, a debug port or an SPI programmer. Three kinds of request can reach it: page erase, global erase and single-word write. The block passes a request on only when a 4-bit hardware key holds the correct value. It also applies secure-mode rules: page zero is fenced off, and the debug port is limited to erasing the whole array.

A page erase takes two register writes. The first loads the page number into a page register. The second writes a magic byte to a trigger register, which has no storage of its own. Global erase and word write arrive on dedicated request inputs. A request that is refused produces a single-cycle reject pulse, and no command goes out. Both the security latch and the requester identity are inputs; this block does not generate them.

Top module: `flash_guard`

## Requirements
- R1: After reset the key register reads 0000. All command outputs and the reject output are low. Any erase or write request made before the key is loaded is rejected.
- R2: The key register is written at register select 0. While it holds anything other than binary 0010, every global erase, page erase and word write is refused with a reject pulse.
- R3: Writing 0x55 to register select 2 starts a page erase. One clock later `cmdPageErase` pulses, and `cmdPage` carries the page last written at register select 1.
- R4: Writing any value other than 0x55 to register select 2 is ignored: no command and no reject. A write to register select 3 is also ignored.
- R5: When `secureMode` is high, a page erase of page zero is refused with a reject pulse, whichever requester issues it.
- R6: When `secureMode` is high, a word write whose page field (upper `PAGE_W` address bits) is zero is refused, whichever requester issues it.
- R7: When `secureMode` and `fromDebug` are both high, page erases and word writes are refused.
- R8: When unlocked, a global erase is passed in every mode, including secure mode from the debug port.
- R9: Each accepted request yields a one-cycle pulse on exactly one command output. Each refused request yields a one-cycle pulse on `reqReject`. At most one of the four pulses is high in any cycle.
- R10: Requests that arrive in the same cycle are ranked global erase first, then page erase, then word write. Only the top-ranked request is judged. The others are dropped without any pulse.
- R11: An accepted word write presents the request address and data unchanged on `cmdAddr` and `cmdData`, one clock after the request.
- R12: The key register takes only the low four bits of the written byte. Rewriting it with any other value locks the block again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 key, 1 page, 2 erase trigger, 3 unused |
| regWdata | input | 8 | Register write data |
| fromDebug | input | 1 | Current request comes from the debug port |
| secureMode | input | 1 | Security latch state |
| globalEraseReq | input | 1 | Global erase request |
| wordWrReq | input | 1 | Word write request |
| wordWrAddr | input | PAGE_W+WORD_W | Word write address, page in upper bits |
| wordWrData | input | DATA_W | Word write data |
| cmdPageErase | output | 1 | Page erase command pulse |
| cmdGlobalErase | output | 1 | Global erase command pulse |
| cmdWrite | output | 1 | Word write command pulse |
| cmdPage | output | PAGE_W | Page to erase |
| cmdAddr | output | PAGE_W+WORD_W | Address of the word to write |
| cmdData | output | DATA_W | Data of the word to write |
| reqReject | output | 1 | Refused request pulse |

## Verification
The bench builds the guard with `PAGE_W`=3, `WORD_W`=2 and `DATA_W`=16. With only eight pages, it can sweep a secure-mode page erase across every page number and confirm that page zero alone is refused. The short address also makes the page-zero test for word writes easy to place in both the secure and the open case. The wide data field carries a recognizable pattern through the write path.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam logic [3:0] UNLOCK_KEY  = 4'b0010;
  localparam logic [7:0] ERASE_MAGIC = 8'h55;
  localparam logic [1:0] SEL_KEY     = 2'd0;
  localparam logic [1:0] SEL_PAGE    = 2'd1;
  localparam logic [1:0] SEL_TRIG    = 2'd2;

  typedef struct packed {
    logic ldKey;
    logic ldPage;
    logic issPageErase;
    logic issGlobal;
    logic issWrite;
    logic reject;
  } guard_strobe_t;
endpackage

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
  import flash_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic [1:0]    regSel,
  input  logic [7:0]    regWdata,
  input  logic          fromDebug,
  input  logic          secureMode,
  input  logic          globalEraseReq,
  input  logic          wordWrReq,
  input  logic          keyOk,
  input  logic          erasePageZero,
  input  logic          writePageZero,
  output guard_strobe_t strb
);
  logic trigHit;
  logic anyReq;
  logic gOk, peOk, wOk;
  logic debugFenced;

  always_comb begin
    trigHit     = regWe && (regSel == SEL_TRIG) && (regWdata == ERASE_MAGIC);
    anyReq      = globalEraseReq || trigHit || wordWrReq;
    debugFenced = secureMode && fromDebug;
    gOk  = globalEraseReq && keyOk;
    peOk = !globalEraseReq && trigHit && keyOk &&
           !debugFenced && !(secureMode && erasePageZero);
    wOk  = !globalEraseReq && !trigHit && wordWrReq && keyOk &&
           !debugFenced && !(secureMode && writePageZero);

    strb              = '0;
    strb.ldKey        = regWe && (regSel == SEL_KEY);
    strb.ldPage       = regWe && (regSel == SEL_PAGE);
    strb.issGlobal    = gOk;
    strb.issPageErase = peOk;
    strb.issWrite     = wOk;
    strb.reject       = anyReq && !(gOk || peOk || wOk);
  end

  // R4
  bad_trigger_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regSel == SEL_TRIG && regWdata != ERASE_MAGIC && !globalEraseReq && !wordWrReq)
      |-> !(strb.reject || strb.issPageErase));

  // R10
  global_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    globalEraseReq |-> !(strb.issPageErase || strb.issWrite));
endmodule

// File: rtl/flash_guard_dp.sv
module flash_guard_dp
  import flash_guard_pkg::*;
#(
  parameter int PAGE_W = 6,
  parameter int WORD_W = 8,
  parameter int DATA_W = 32,
  localparam int ADDR_W = PAGE_W + WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  guard_strobe_t     strb,
  input  logic [7:0]        regWdata,
  input  logic              fromDebug,
  input  logic              secureMode,
  input  logic [ADDR_W-1:0] wordWrAddr,
  input  logic [DATA_W-1:0] wordWrData,
  output logic              keyOk,
  output logic              erasePageZero,
  output logic              writePageZero,
  output logic              cmdPageErase,
  output logic              cmdGlobalErase,
  output logic              cmdWrite,
  output logic [PAGE_W-1:0] cmdPage,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData,
  output logic              reqReject
);
  logic [3:0]        keyReg;
  logic [PAGE_W-1:0] pageReg;

  assign keyOk         = (keyReg == UNLOCK_KEY);
  assign erasePageZero = (pageReg == '0);
  assign writePageZero = (wordWrAddr[ADDR_W-1 -: PAGE_W] == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyReg  <= '0;
      pageReg <= '0;
    end else begin
      if (strb.ldKey)  keyReg  <= regWdata[3:0];
      if (strb.ldPage) pageReg <= regWdata[PAGE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdPageErase   <= 1'b0;
      cmdGlobalErase <= 1'b0;
      cmdWrite       <= 1'b0;
      reqReject      <= 1'b0;
      cmdPage        <= '0;
      cmdAddr        <= '0;
      cmdData        <= '0;
    end else begin
      cmdPageErase   <= strb.issPageErase;
      cmdGlobalErase <= strb.issGlobal;
      cmdWrite       <= strb.issWrite;
      reqReject      <= strb.reject;
      if (strb.issPageErase) cmdPage <= pageReg;
      if (strb.issWrite) begin
        cmdAddr <= wordWrAddr;
        cmdData <= wordWrData;
      end
    end
  end

  // R9
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdPageErase, cmdGlobalErase, cmdWrite, reqReject}));

  // R2
  cmd_needs_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPageErase || cmdGlobalErase || cmdWrite) |-> ($past(keyReg) == UNLOCK_KEY));

  // R5
  secure_page0_erase_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdPageErase |-> !($past(secureMode) && cmdPage == '0));

  // R6
  secure_page0_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrite |-> !($past(secureMode) && cmdAddr[ADDR_W-1 -: PAGE_W] == '0));

  // R7
  secure_debug_fence_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPageErase || cmdWrite) |-> !($past(secureMode) && $past(fromDebug)));
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int PAGE_W = 6,
  parameter int WORD_W = 8,
  parameter int DATA_W = 32,
  localparam int ADDR_W = PAGE_W + WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [7:0]        regWdata,
  input  logic              fromDebug,
  input  logic              secureMode,
  input  logic              globalEraseReq,
  input  logic              wordWrReq,
  input  logic [ADDR_W-1:0] wordWrAddr,
  input  logic [DATA_W-1:0] wordWrData,
  output logic              cmdPageErase,
  output logic              cmdGlobalErase,
  output logic              cmdWrite,
  output logic [PAGE_W-1:0] cmdPage,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData,
  output logic              reqReject
);
  guard_strobe_t strb;
  logic keyOk, erasePageZero, writePageZero;

  flash_guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .fromDebug(fromDebug), .secureMode(secureMode), .globalEraseReq(globalEraseReq),
    .wordWrReq(wordWrReq), .keyOk(keyOk), .erasePageZero(erasePageZero),
    .writePageZero(writePageZero), .strb(strb)
  );

  flash_guard_dp #(.PAGE_W(PAGE_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWdata(regWdata), .fromDebug(fromDebug),
    .secureMode(secureMode), .wordWrAddr(wordWrAddr), .wordWrData(wordWrData),
    .keyOk(keyOk), .erasePageZero(erasePageZero), .writePageZero(writePageZero),
    .cmdPageErase(cmdPageErase), .cmdGlobalErase(cmdGlobalErase), .cmdWrite(cmdWrite),
    .cmdPage(cmdPage), .cmdAddr(cmdAddr), .cmdData(cmdData), .reqReject(reqReject)
  );
endmodule

// File: tb/flash_guard_bench.sv
module flash_guard_bench;
  localparam int PW = 3;
  localparam int WW = 2;
  localparam int DW = 16;
  localparam int AW = PW + WW;

  logic clk = 1'b0;
  logic rstN;
  logic regWe;
  logic [1:0] regSel;
  logic [7:0] regWdata;
  logic fromDebug, secureMode, globalEraseReq, wordWrReq;
  logic [AW-1:0] wordWrAddr;
  logic [DW-1:0] wordWrData;
  logic cmdPageErase, cmdGlobalErase, cmdWrite, reqReject;
  logic [PW-1:0] cmdPage;
  logic [AW-1:0] cmdAddr;
  logic [DW-1:0] cmdData;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [3:0]    pulses;
    logic [PW-1:0] page;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];

  logic [3:0]    keyM;
  logic [PW-1:0] pageM;

  always #4 clk = ~clk;

  flash_guard #(.PAGE_W(PW), .WORD_W(WW), .DATA_W(DW)) u_flash_guard (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .fromDebug(fromDebug), .secureMode(secureMode), .globalEraseReq(globalEraseReq),
    .wordWrReq(wordWrReq), .wordWrAddr(wordWrAddr), .wordWrData(wordWrData),
    .cmdPageErase(cmdPageErase), .cmdGlobalErase(cmdGlobalErase), .cmdWrite(cmdWrite),
    .cmdPage(cmdPage), .cmdAddr(cmdAddr), .cmdData(cmdData), .reqReject(reqReject)
  );

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected outcome.
  task automatic step(string tag, logic we, logic [1:0] sel, logic [7:0] wd,
                      logic dbg, logic sec, logic g, logic w,
                      logic [AW-1:0] wa, logic [DW-1:0] wdat);
    exp_t e;
    logic trig, unlocked;
    @(negedge clk);
    regWe = we; regSel = sel; regWdata = wd; fromDebug = dbg; secureMode = sec;
    globalEraseReq = g; wordWrReq = w; wordWrAddr = wa; wordWrData = wdat;
    e = '0;
    trig = we && sel == 2'd2 && wd == 8'h55;
    unlocked = (keyM == 4'b0010);
    if (g) begin
      if (unlocked) e.pulses = 4'b0100; else e.pulses = 4'b0001;
    end else if (trig) begin
      if (unlocked && !(sec && dbg) && !(sec && pageM == 0)) begin
        e.pulses = 4'b1000; e.page = pageM;
      end else e.pulses = 4'b0001;
    end else if (w) begin
      if (unlocked && !(sec && dbg) && !(sec && wa[AW-1 -: PW] == 0)) begin
        e.pulses = 4'b0010; e.addr = wa; e.data = wdat;
      end else e.pulses = 4'b0001;
    end
    if (we && sel == 2'd0) keyM = wd[3:0];
    if (we && sel == 2'd1) pageM = wd[PW-1:0];
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, '0, '0);
  endtask

  // Monitor: just after each edge, compares registered outputs against the queue.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && expQ.size() > 0) begin
        exp_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({t, " pulses"}, DW'({cmdPageErase, cmdGlobalErase, cmdWrite, reqReject}), DW'(e.pulses));
        if (e.pulses[3]) check({t, " page"}, DW'(cmdPage), DW'(e.page));
        if (e.pulses[1]) begin
          check({t, " addr"}, DW'(cmdAddr), DW'(e.addr));
          check({t, " data"}, cmdData, e.data);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    keyM = 4'b0000; pageM = '0;
    rstN = 1'b0; regWe = 0; regSel = 0; regWdata = 0; fromDebug = 0; secureMode = 0;
    globalEraseReq = 0; wordWrReq = 0; wordWrAddr = '0; wordWrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1 reset outputs", DW'({cmdPageErase, cmdGlobalErase, cmdWrite, reqReject}), '0);
    step("R1 global before key", 0, 0, 0, 0, 0, 1, 0, '0, '0);
    step("R1 trigger before key", 1, 2, 8'h55, 0, 0, 0, 0, '0, '0);
    step("R2 write before key", 0, 0, 0, 0, 0, 0, 1, 5'b10001, 16'h1234);
    step("R2 wrong key", 1, 0, 8'h03, 0, 0, 0, 0, '0, '0);
    step("R2 global wrong key", 0, 0, 0, 0, 0, 1, 0, '0, '0);
    step("R12 key low nibble", 1, 0, 8'hF2, 0, 0, 0, 0, '0, '0);
    step("R12 global unlocked", 0, 0, 0, 0, 0, 1, 0, '0, '0);
    step("R3 load page", 1, 1, 8'd5, 0, 0, 0, 0, '0, '0);
    step("R3 page erase", 1, 2, 8'h55, 0, 0, 0, 0, '0, '0);
    idle("R9 pulse ends");
    step("R4 trigger 0x54", 1, 2, 8'h54, 0, 0, 0, 0, '0, '0);
    step("R4 trigger 0xAA", 1, 2, 8'hAA, 0, 0, 0, 0, '0, '0);
    step("R4 select 3", 1, 3, 8'h55, 0, 0, 0, 0, '0, '0);
    step("R11 word write", 0, 0, 0, 0, 0, 0, 1, 5'b10001, 16'hBEEF);
    idle("R9 write pulse ends");
    for (int p = 0; p < (1 << PW); p++) begin
      step("R5 secure load page", 1, 1, 8'(p), 0, 1, 0, 0, '0, '0);
      step("R5 secure page sweep", 1, 2, 8'h55, 0, 1, 0, 0, '0, '0);
    end
    step("R5 debug load page0", 1, 1, 8'd0, 1, 1, 0, 0, '0, '0);
    step("R5 debug page0 erase", 1, 2, 8'h55, 1, 1, 0, 0, '0, '0);
    step("R6 secure write page0", 0, 0, 0, 0, 1, 0, 1, 5'b00011, 16'hA5A5);
    step("R6 secure write page2", 0, 0, 0, 0, 1, 0, 1, 5'b01010, 16'h5A5A);
    step("R7 debug write secure", 0, 0, 0, 1, 1, 0, 1, 5'b01010, 16'h0F0F);
    step("R7 debug load page3", 1, 1, 8'd3, 1, 1, 0, 0, '0, '0);
    step("R7 debug erase secure", 1, 2, 8'h55, 1, 1, 0, 0, '0, '0);
    step("R8 debug global secure", 0, 0, 0, 1, 1, 1, 0, '0, '0);
    step("R8 cpu global secure", 0, 0, 0, 0, 1, 1, 0, '0, '0);
    step("R5 open load page0", 1, 1, 8'd0, 1, 0, 0, 0, '0, '0);
    step("R5 open debug page0 erase", 1, 2, 8'h55, 1, 0, 0, 0, '0, '0);
    step("R6 open write page0", 0, 0, 0, 1, 0, 0, 1, 5'b00010, 16'hC3C3);
    step("R10 global beats all", 1, 2, 8'h55, 0, 0, 1, 1, 5'b11111, 16'hFFFF);
    step("R10 erase beats write", 1, 2, 8'h55, 0, 0, 0, 1, 5'b11111, 16'hFFFF);
    step("R12 relock", 1, 0, 8'h00, 0, 0, 0, 0, '0, '0);
    step("R12 write after relock", 0, 0, 0, 0, 0, 0, 1, 5'b10000, 16'h7777);
    step("R10 locked global plus write", 0, 0, 0, 0, 0, 1, 1, 5'b10000, 16'h7777);
    idle("R9 drain");
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule